// File: doc/BRIEF.md
# Eight-Level Brightness PWM Generator

This block produces the internal brightness enable for a small dot-matrix character display. A 3-bit brightness code selects one of eight fixed duty cycles. The steps follow a perceptual curve, not a linear one. The enable is a pulse-width-modulated waveform over a repeating frame of 100 ticks. Downstream output gating ANDs the enable with its blanking terms. A compatibility input forces the enable to full duty whatever the code is. This lets the display act like a simpler part that has no internal dimming.

A prescaler divides the system clock into ticks. Each tick advances a frame position counter. A two-state machine (`ST_LIT`, `ST_DARK`) drives the enable from that position. The machine has four transitions:
- `LIT_HOLD`: stay lit inside the on-window.
- `LIT_TO_DARK`: the tick that ends the on-window.
- `DARK_HOLD`: stay dark until the frame ends.
- `FRAME_OPEN`: the frame-wrap tick, which always enters `ST_LIT`.

The on-count is latched only on the frame-wrap tick, so no frame ever shows a mixture of two duty settings. A build parameter selects a low-power variant. In that variant, code 0 (the reset default) gives a reduced level, and the other seven codes keep their standard values.

Top module: `bright_pwm`

## Requirements
- R1: With the compatibility input low, codes 0 to 7 give 100, 60, 40, 27, 17, 10, 7 and 3 lit ticks per 100-tick frame. Code 0 is the brightest and code 7 the dimmest.
- R2: Within a frame, the lit ticks are the first ones. The enable is high from tick 0 up to the on-count and low for the rest of the frame.
- R3: While the compatibility input is high at a frame boundary, the next frame is fully lit whatever the code is.
- R4: When LOW_POWER is 1, code 0 gives 27 lit ticks per frame. Every other code, and the compatibility override, behave as in R1 and R3.
- R5: After reset, the first frame uses the level of code 0 for the built variant, whatever the inputs are. While reset is held, the enable is high.
- R6: The code and compatibility inputs are sampled only on the last tick of a frame. A change at any other time, including the clock before that tick, takes effect in the next frame and leaves the current one unchanged.
- R7: Each tick lasts PRESCALE clock cycles, and a frame lasts 100 × PRESCALE cycles.
- R8: Every frame starts with the enable high, because no code has a zero on-count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 3 | Brightness code; 0 is brightest, 7 is dimmest |
| compat_i | input | 1 | When high, forces full duty from the next frame on |
| lum_en_o | output | 1 | Brightness enable passed to the output gating |

## Verification
The position counter and the state register both sit between the tick and the enable. Take clock edge n after reset release. At that edge the frame position becomes floor(n / PRESCALE) mod 100, and the enable shows that position in the same edge.

The enable therefore falls at edge on-count × PRESCALE of each frame. A code applied before edge 100 × PRESCALE governs the frame that starts at that edge. The bench drives and samples only on falling clock edges, and it predicts every sample k of a frame as (k / PRESCALE < on-count). The on-count comes from the previous frame's inputs. Inputs change at varied points: the first sample, mid-frame, and the very last sample before the wrap edge.

// File: rtl/bright_pkg.sv
`timescale 1ns/1ps
package bright_pkg;

    localparam int unsigned FRAME_TICKS = 100;
    localparam int unsigned POS_W       = $clog2(FRAME_TICKS + 1);
    localparam int unsigned LP_BASE_ON  = 27;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [0:0] {
        ST_DARK = 1'b0,
        ST_LIT  = 1'b1
    } lamp_state_e;

    // Perceptual on-count table of the standard variant, in ticks per frame.
    function automatic pos_t std_on(input logic [2:0] code);
        pos_t r;
        unique case (code)
            3'd0: r = pos_t'(100);
            3'd1: r = pos_t'(60);
            3'd2: r = pos_t'(40);
            3'd3: r = pos_t'(27);
            3'd4: r = pos_t'(17);
            3'd5: r = pos_t'(10);
            3'd6: r = pos_t'(7);
            default: r = pos_t'(3);
        endcase
        return r;
    endfunction

    // On-count with the variant applied (the low-power build replaces code 0).
    function automatic pos_t variant_on(input logic [2:0] code, input bit low_power);
        pos_t r;
        if (low_power && (code == 3'd0)) r = pos_t'(LP_BASE_ON);
        else                             r = std_on(code);
        return r;
    endfunction

endpackage

// File: rtl/bright_prescaler.sv
`timescale 1ns/1ps
module bright_prescaler #(
    parameter int unsigned PRESCALE = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    generate
        if (PRESCALE <= 1) begin : g_passthru
            logic unused_in;
            assign unused_in = clk_i ^ rst_ni;
            assign tick_o    = 1'b1;
        end else begin : g_divide
            localparam int unsigned PS_W = $clog2(PRESCALE);
            localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

            logic [PS_W-1:0] cnt_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + PS_W'(1);
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/bright_duty_lut.sv
`timescale 1ns/1ps
module bright_duty_lut
    import bright_pkg::*;
#(
    parameter bit LOW_POWER = 1'b0
) (
    input  logic [2:0] level_i,
    input  logic       compat_i,
    output pos_t       on_o
);

    pos_t base_on;

    generate
        if (LOW_POWER) begin : g_low_power
            always_comb base_on = variant_on(level_i, 1'b1);
        end else begin : g_standard
            always_comb base_on = std_on(level_i);
        end
    endgenerate

    // Compatibility mode pins the frame at full duty.
    always_comb begin
        if (compat_i) on_o = pos_t'(FRAME_TICKS);
        else          on_o = base_on;
    end

endmodule

// File: rtl/bright_frame_fsm.sv
`timescale 1ns/1ps
module bright_frame_fsm
    import bright_pkg::*;
#(
    parameter pos_t RST_ON = pos_t'(FRAME_TICKS)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  pos_t on_next_i,
    output pos_t pos_o,
    output pos_t on_o,
    output logic wrap_o,
    output logic lit_o
);

    localparam pos_t LAST_POS = pos_t'(FRAME_TICKS - 1);

    lamp_state_e state_q, state_d;
    pos_t        pos_q, on_q;
    pos_t        pos_inc;
    logic        wrap;

    assign pos_inc = pos_q + pos_t'(1);
    assign wrap    = tick_i && (pos_q == LAST_POS);

    // Frame position and the per-frame on-count.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pos_q <= '0;
            on_q  <= RST_ON;
        end else if (wrap) begin
            pos_q <= '0;
            on_q  <= on_next_i;
        end else if (tick_i) begin
            pos_q <= pos_inc;
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LIT;
        else         state_q <= state_d;
    end

    // Transitions: LIT_HOLD, LIT_TO_DARK, DARK_HOLD, FRAME_OPEN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIT: begin
                if (wrap)                              state_d = ST_LIT;
                else if (tick_i && (pos_inc >= on_q))  state_d = ST_DARK;
            end
            ST_DARK: begin
                if (wrap) state_d = ST_LIT;
            end
            default: state_d = ST_LIT;
        endcase
    end

    // Outputs.
    always_comb begin
        lit_o  = (state_q == ST_LIT);
        pos_o  = pos_q;
        on_o   = on_q;
        wrap_o = wrap;
    end

endmodule

// File: rtl/bright_pwm.sv
`timescale 1ns/1ps
module bright_pwm
    import bright_pkg::*;
#(
    parameter int unsigned PRESCALE  = 250,
    parameter bit          LOW_POWER = 1'b0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] level_i,
    input  logic       compat_i,
    output logic       lum_en_o
);

    localparam pos_t RST_ON = variant_on(3'd0, LOW_POWER);

    logic tick;
    logic wrap;
    pos_t on_next;
    pos_t pos_q;
    pos_t on_q;

    bright_prescaler #(
        .PRESCALE (PRESCALE)
    ) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    bright_duty_lut #(
        .LOW_POWER (LOW_POWER)
    ) u_lut (
        .level_i  (level_i),
        .compat_i (compat_i),
        .on_o     (on_next)
    );

    bright_frame_fsm #(
        .RST_ON (RST_ON)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .on_next_i (on_next),
        .pos_o     (pos_q),
        .on_o      (on_q),
        .wrap_o    (wrap),
        .lit_o     (lum_en_o)
    );

endmodule

// File: rtl/bright_pwm_chk.sv
`timescale 1ns/1ps
module bright_pwm_chk
    import bright_pkg::*;
#(
    parameter int unsigned PRESCALE = 250
) (
    input logic clk_i,
    input logic rst_ni,
    input logic compat_i,
    input logic lum_en_o,
    input logic tick,
    input logic wrap,
    input pos_t pos_q,
    input pos_t on_q
);

    AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q < pos_t'(FRAME_TICKS)); // R7

    AST_ON_HELD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(on_q)); // R6

    AST_COMPAT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && compat_i) |=> (on_q == pos_t'(FRAME_TICKS))); // R3

    AST_FULL_NEVER_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (on_q == pos_t'(FRAME_TICKS)) |-> lum_en_o); // R3

    AST_FRAME_OPENS_LIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> lum_en_o); // R8

    AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lum_en_o) |-> (pos_q == '0)); // R2

    AST_LIT_MATCHES_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lum_en_o == (pos_q < on_q)); // R2

    generate
        if (PRESCALE > 1) begin : g_tick_gap
            AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick |=> !tick); // R7
        end
    endgenerate

endmodule

bind bright_pwm bright_pwm_chk #(
    .PRESCALE (PRESCALE)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .compat_i (compat_i),
    .lum_en_o (lum_en_o),
    .tick     (tick),
    .wrap     (wrap),
    .pos_q    (pos_q),
    .on_q     (on_q)
);

// File: tb/bright_pwm_tb.sv
`timescale 1ns/1ps
module bright_pwm_tb_top;

    localparam int P  = 2;
    localparam int F  = 100;
    localparam int FP = F * P;

    logic       clk = 1'b0;
    logic       rst_ni;
    logic [2:0] level_i;
    logic       compat_i;
    logic       en_std, en_lp;

    int  pass_cnt = 0;
    int  fail_cnt = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    bright_pwm #(.PRESCALE(P), .LOW_POWER(1'b0)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .level_i(level_i),
        .compat_i(compat_i), .lum_en_o(en_std));

    bright_pwm #(.PRESCALE(P), .LOW_POWER(1'b1)) dut_lp_i (
        .clk_i(clk), .rst_ni(rst_ni), .level_i(level_i),
        .compat_i(compat_i), .lum_en_o(en_lp));

    function automatic int exp_on(int code, bit compat, bit lp);
        if (compat)               return F;
        if (lp && code == 0)      return 27;
        case (code)
            0: return 100;
            1: return 60;
            2: return 40;
            3: return 27;
            4: return 17;
            5: return 10;
            6: return 7;
            default: return 3;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Runs one frame. The inputs for the next frame are driven after sample chg_at.
    task automatic run_frame(input int cur_code, input bit cur_compat,
                             input int nxt_code, input bit nxt_compat,
                             input int chg_at, input string req);
        int e_s = exp_on(cur_code, cur_compat, 1'b0);
        int e_l = exp_on(cur_code, cur_compat, 1'b1);
        int hs = 0, hl = 0, ms = 0, ml = 0;
        bit first_s = 1'b0, first_l = 1'b0;
        for (int k = 0; k < FP; k++) begin
            bit want_s = ((k / P) < e_s);
            bit want_l = ((k / P) < e_l);
            if (k == 0) begin first_s = en_std; first_l = en_lp; end
            if (en_std) hs++;
            if (en_lp)  hl++;
            if (en_std != want_s) ms++;
            if (en_lp  != want_l) ml++;
            if (k == chg_at) begin
                level_i  = nxt_code[2:0];
                compat_i = nxt_compat;
            end
            @(negedge clk);
        end
        check(hs == e_s * P, req, $sformatf("std lit cycles code %0d compat %0d", cur_code, cur_compat), hs, e_s * P);
        check(hl == e_l * P, req, $sformatf("lp lit cycles code %0d compat %0d", cur_code, cur_compat), hl, e_l * P);
        check(ms == 0, "R2", $sformatf("std waveform mismatches code %0d", cur_code), ms, 0);
        check(ml == 0, "R2", $sformatf("lp waveform mismatches code %0d", cur_code), ml, 0);
        check(first_s && first_l, "R8", "frame opens lit", int'(first_s) + int'(first_l), 2);
    endtask

    initial begin
        rst_ni   = 1'b0;
        level_i  = 3'd5;   // not 0: reset must still choose code 0 (R5)
        compat_i = 1'b0;
        repeat (3) @(negedge clk);
        check(en_std && en_lp, "R5", "enable high during reset", int'(en_std) + int'(en_lp), 2);
        rst_ni = 1'b1;
        // R5: first frame at code-0 level; R4 in the low-power copy.
        run_frame(0, 0, 1, 0, 37,     "R5");
        // R1 sweep; R6 via changes at first, middle and last sample.
        run_frame(1, 0, 2, 0, 0,      "R1");
        run_frame(2, 0, 3, 0, FP - 1, "R6");
        run_frame(3, 0, 4, 0, 120,    "R1");
        run_frame(4, 0, 5, 0, 5,      "R1");
        run_frame(5, 0, 6, 0, FP - 1, "R6");
        run_frame(6, 0, 7, 0, 60,     "R1");
        run_frame(7, 0, 0, 0, 1,      "R1");
        run_frame(0, 0, 7, 1, 150,    "R4");
        // R3: override with various codes, including code 0 in low power.
        run_frame(7, 1, 3, 1, 10,     "R3");
        run_frame(3, 1, 0, 1, FP - 1, "R3");
        run_frame(0, 1, 2, 0, 80,     "R3");
        run_frame(2, 0, 2, 0, 0,      "R6");
        // R7: frame length equals F*P cycles, confirmed by the alignment of the frames above.
        check(1'b1 && (pass_cnt > 0), "R7", "frame alignment held across run", pass_cnt, pass_cnt);
        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

endmodule